// File: doc/BRIEF.md
# Command-Pointer Register Interface

This block is the byte-level register front end of a small sensor controller. A serial-bus slave, outside this block, hands it one decoded transaction at a time: send-byte, write-byte, write-word, read-byte or read-word. Each transaction carries a kind code, a command byte and up to two data bytes. A command byte with its most significant bit set loads an 8-bit command register. The low four bits of that register form a pointer. Later writes and reads go to the 16-entry register space through this pointer. Bit 6 of a command byte requests an interrupt clear, and bit 5 flags word-mode transfers.

A sequencer steps each accepted transaction through a fixed list of states: `ST_IDLE`, `ST_CMD`, `ST_WR_LO`, `ST_WR_HI` and `ST_RD`. It drives one register-bank write or one read result per step. The named transitions are as follows. `ST_IDLE`→`ST_CMD` is taken for send-byte, write-byte and write-word. `ST_IDLE`→`ST_RD` is taken for read-byte and read-word. `ST_CMD`→`ST_WR_LO` is taken for a write with a valid command byte. `ST_CMD`→`ST_IDLE` is taken for a send-byte or for an invalid command byte. `ST_WR_LO`→`ST_WR_HI` is taken for a word write. Every other state returns to `ST_IDLE`. The bank applies fixed field masks per address and exposes the control, timing, two thresholds and interrupt-control registers to the neighbouring blocks.

Top module: `cmdptr_regif`

## Requirements
- R1: After reset the command register reads 00h, control 00h, timing 02h, both thresholds 0000h, interrupt control 00h, and `txn_ready` is 1.
- R2: A command byte with bit 7 set loads the command register. Bits 3:0 become the pointer, bit 5 is kept as the word flag, bit 7 reads 1, and bits 6 and 4 read 0. A command byte with bit 7 clear leaves the command register unchanged, and any write that carries it is dropped.
- R3: A command byte with bits 7 and 6 set raises `int_clear` for exactly one cycle. Bit 6 never reads back as 1.
- R4: A write-byte writes its low data byte at the pointer that its own command byte loads.
- R5: A write-word writes the low data byte at the pointer and the high data byte at pointer+1, modulo 16, in one transaction.
- R6: A read-byte returns {00h, reg[pointer]}. A read-word returns {reg[pointer+1], reg[pointer]}. A read leaves the command register unchanged.
- R7: Reserved bits read 0 whatever is written. The kept bits are control 03h (address 0), timing 1Bh (address 1), thresholds FFh (addresses 2 to 5) and interrupt control 3Fh (address 6).
- R8: Addresses 7 to 15 read 00h, and writes to them change nothing.
- R9: `txn_ready` is 1 only in `ST_IDLE`. `rd_valid` is high for exactly the one `ST_RD` cycle, which is the cycle after the read is accepted.
- R10: Writing 03h to control sets `power_ctl` to 3 and reads back 03h. Writing 00h clears it.
- R11: Kind codes: 0 is send-byte, 1 is write-byte, 2 is write-word, 3 is read-byte and 4 is read-word. Codes 5 to 7 are accepted and do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Sequencer idle, transaction accepted when valid |
| txn_kind | input | 3 | Transaction kind code (R11) |
| txn_cmd | input | 8 | Command byte |
| txn_lo | input | 8 | First data byte |
| txn_hi | input | 8 | Second data byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result, high byte 0 for read-byte |
| int_clear | output | 1 | One-cycle interrupt-clear pulse |
| cmd_value | output | 8 | Command register contents |
| power_ctl | output | 2 | Power field of control |
| timing_cfg | output | 8 | Timing register |
| thr_low | output | 16 | Low threshold {addr 3, addr 2} |
| thr_high | output | 16 | High threshold {addr 5, addr 4} |
| intr_cfg | output | 8 | Interrupt-control register |

## Verification
The assertions check the following on every cycle: the clear pulse lasts one cycle; the command register has bit 7 set or is zero, and bits 6 and 4 are clear; the reserved bits of the exposed registers stay 0; and reads leave the command register alone while the sequencer is busy. Only the bench scenarios can show the data routing. These cover pointer-steered byte and word writes, the high byte landing at pointer+1 with wrap-around, read-word byte order, dropped non-command writes, and unmapped addresses staying at zero.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        K_SEND   = 3'd0,
        K_WRBYTE = 3'd1,
        K_WRWORD = 3'd2,
        K_RDBYTE = 3'd3,
        K_RDWORD = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD
    } seq_state_e;

    // Kept bits per register address; zero means nothing stored there.
    function automatic logic [BYTE_W-1:0] keep_mask(input int addr);
        case (addr)
            0:       return 8'h03;
            1:       return 8'h1B;
            2, 3, 4, 5: return 8'hFF;
            6:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] init_value(input int addr);
        return (addr == 1) ? 8'h02 : 8'h00;
    endfunction

endpackage

// File: rtl/regif_seq.sv
module regif_seq
    import regif_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [2:0]        txn_kind,
    input  logic [BYTE_W-1:0] txn_cmd,
    input  logic [BYTE_W-1:0] txn_lo,
    input  logic [BYTE_W-1:0] txn_hi,
    output logic              txn_ready,
    output logic              int_clear,
    output logic [BYTE_W-1:0] cmd_value,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_valid,
    output logic              rd_word,
    output logic [ADDR_W-1:0] rd_addr_lo,
    output logic [ADDR_W-1:0] rd_addr_hi
);

    seq_state_e        state_q, state_d;
    logic [2:0]        kind_q;
    logic [BYTE_W-1:0] cmdb_q, lo_q, hi_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [ADDR_W-1:0] ptr, ptr_next;
    logic              cmd_ok, cmd_load, is_write;

    assign ptr      = cmd_q[ADDR_W-1:0];
    assign ptr_next = ADDR_W'(ptr + 1'b1);
    assign cmd_ok   = cmdb_q[BYTE_W-1];
    assign is_write = (kind_q == K_WRBYTE) || (kind_q == K_WRWORD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (txn_valid) begin
                    if (txn_kind == K_SEND || txn_kind == K_WRBYTE || txn_kind == K_WRWORD)
                        state_d = ST_CMD;
                    else if (txn_kind == K_RDBYTE || txn_kind == K_RDWORD)
                        state_d = ST_RD;
                end
            end
            ST_CMD:   state_d = (cmd_ok && is_write) ? ST_WR_LO : ST_IDLE;
            ST_WR_LO: state_d = (kind_q == K_WRWORD) ? ST_WR_HI : ST_IDLE;
            ST_WR_HI: state_d = ST_IDLE;
            ST_RD:    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        txn_ready  = (state_q == ST_IDLE);
        cmd_load   = (state_q == ST_CMD) && cmd_ok;
        int_clear  = cmd_load && cmdb_q[6];
        wr_en      = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
        wr_addr    = (state_q == ST_WR_HI) ? ptr_next : ptr;
        wr_data    = (state_q == ST_WR_HI) ? hi_q : lo_q;
        rd_valid   = (state_q == ST_RD);
        rd_word    = (kind_q == K_RDWORD);
        rd_addr_lo = ptr;
        rd_addr_hi = ptr_next;
    end

    // Transaction capture and command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= '0;
            cmdb_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            cmd_q  <= '0;
        end else begin
            if (txn_ready && txn_valid) begin
                kind_q <= txn_kind;
                cmdb_q <= txn_cmd;
                lo_q   <= txn_lo;
                hi_q   <= txn_hi;
            end
            if (cmd_load)
                cmd_q <= {1'b1, 1'b0, cmdb_q[5], 1'b0, cmdb_q[3:0]};
        end
    end

    assign cmd_value = cmd_q;

endmodule

// File: rtl/regif_bank.sv
module regif_bank
    import regif_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr_lo,
    input  logic [ADDR_W-1:0]             rd_addr_hi,
    output logic [BYTE_W-1:0]             rd_lo,
    output logic [BYTE_W-1:0]             rd_hi,
    output logic [NREG-1:0][BYTE_W-1:0]   regs
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] MASK = keep_mask(i);
        localparam logic [BYTE_W-1:0] INIT = init_value(i);
        if (MASK != '0) begin : g_store
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= INIT;
                else if (wr_en && wr_addr == ADDR_W'(i))
                    q <= wr_data & MASK;
            end
            assign regs[i] = q;
        end else begin : g_empty
            assign regs[i] = '0;
        end
    end

    assign rd_lo = regs[rd_addr_lo];
    assign rd_hi = regs[rd_addr_hi];

endmodule

// File: rtl/cmdptr_regif.sv
module cmdptr_regif
    import regif_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_valid,
    output logic        txn_ready,
    input  logic [2:0]  txn_kind,
    input  logic [7:0]  txn_cmd,
    input  logic [7:0]  txn_lo,
    input  logic [7:0]  txn_hi,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        int_clear,
    output logic [7:0]  cmd_value,
    output logic [1:0]  power_ctl,
    output logic [7:0]  timing_cfg,
    output logic [15:0] thr_low,
    output logic [15:0] thr_high,
    output logic [7:0]  intr_cfg
);

    localparam int NREG = 1 << ADDR_W;

    logic                        wr_en, rd_word;
    logic [ADDR_W-1:0]           wr_addr, rd_addr_lo, rd_addr_hi;
    logic [BYTE_W-1:0]           wr_data, rd_lo, rd_hi;
    logic [NREG-1:0][BYTE_W-1:0] regs;

    regif_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_valid  (txn_valid),
        .txn_kind   (txn_kind),
        .txn_cmd    (txn_cmd),
        .txn_lo     (txn_lo),
        .txn_hi     (txn_hi),
        .txn_ready  (txn_ready),
        .int_clear  (int_clear),
        .cmd_value  (cmd_value),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_valid   (rd_valid),
        .rd_word    (rd_word),
        .rd_addr_lo (rd_addr_lo),
        .rd_addr_hi (rd_addr_hi)
    );

    regif_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr_lo (rd_addr_lo),
        .rd_addr_hi (rd_addr_hi),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .regs       (regs)
    );

    assign rd_data    = {rd_word ? rd_hi : 8'h00, rd_lo};
    assign power_ctl  = regs[0][1:0];
    assign timing_cfg = regs[1];
    assign thr_low    = {regs[3], regs[2]};
    assign thr_high   = {regs[5], regs[4]};
    assign intr_cfg   = regs[6];

endmodule

// File: rtl/cmdptr_regif_chk.sv
module cmdptr_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_ready,
    input logic       rd_valid,
    input logic       int_clear,
    input logic [7:0] cmd_value,
    input logic [7:0] timing_cfg,
    input logic [7:0] intr_cfg
);

    a_r3_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear |=> !int_clear);

    a_r3_clear_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_value[6]);

    a_r2_cmd_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_value != 8'h00) |-> (cmd_value[7] && !cmd_value[4]));

    a_r9_busy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !txn_ready);

    a_r9_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r6_read_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> $stable(cmd_value));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_cfg[7:5] == 3'b000) && !timing_cfg[2] && (intr_cfg[7:6] == 2'b00));

endmodule

bind cmdptr_regif cmdptr_regif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_ready  (txn_ready),
    .rd_valid   (rd_valid),
    .int_clear  (int_clear),
    .cmd_value  (cmd_value),
    .timing_cfg (timing_cfg),
    .intr_cfg   (intr_cfg)
);

// File: tb/cmdptr_regif_test.sv
`timescale 1ns/1ps
module cmdptr_regif_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic [2:0]  txn_kind = '0;
    logic [7:0]  txn_cmd = '0, txn_lo = '0, txn_hi = '0;
    logic        txn_ready, rd_valid, int_clear;
    logic [15:0] rd_data, thr_low, thr_high;
    logic [7:0]  cmd_value, timing_cfg, intr_cfg;
    logic [1:0]  power_ctl;

    always #10 clk = ~clk;

    cmdptr_regif uut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_kind(txn_kind), .txn_cmd(txn_cmd), .txn_lo(txn_lo), .txn_hi(txn_hi),
        .rd_valid(rd_valid), .rd_data(rd_data), .int_clear(int_clear),
        .cmd_value(cmd_value), .power_ctl(power_ctl), .timing_cfg(timing_cfg),
        .thr_low(thr_low), .thr_high(thr_high), .intr_cfg(intr_cfg)
    );

    int total = 0, bad = 0, clr_seen = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  mdl [16];
    logic [7:0]  mcmd = 8'h00;

    function automatic logic [7:0] kept(input int a);
        if (a == 0) return 8'h03;
        if (a == 1) return 8'h1B;
        if (a >= 2 && a <= 5) return 8'hFF;
        if (a == 6) return 8'h3F;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [7:0] c, input logic [7:0] l, input logic [7:0] h);
        while (!txn_ready) @(negedge clk);
        txn_valid = 1'b1; txn_kind = k; txn_cmd = c; txn_lo = l; txn_hi = h;
        @(negedge clk);
        txn_valid = 1'b0;
        while (!txn_ready) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic bit model_cmd(input logic [7:0] c);
        if (!c[7]) return 1'b0;
        mcmd = {1'b1, 1'b0, c[5], 1'b0, c[3:0]};
        return 1'b1;
    endfunction

    task automatic send(input logic [7:0] c);
        void'(model_cmd(c));
        drive(3'd0, c, 8'h00, 8'h00);
    endtask

    task automatic wbyte(input logic [7:0] c, input logic [7:0] d);
        if (model_cmd(c)) mdl[mcmd[3:0]] = d & kept(mcmd[3:0]);
        drive(3'd1, c, d, 8'h00);
    endtask

    task automatic wword(input logic [7:0] c, input logic [7:0] l, input logic [7:0] h);
        if (model_cmd(c)) begin
            logic [3:0] p;
            p = mcmd[3:0];
            mdl[p] = l & kept(p);
            mdl[4'(p + 1)] = h & kept(4'(p + 1));
        end
        drive(3'd2, c, l, h);
    endtask

    task automatic rd(input bit word, input string tag);
        logic [3:0] p;
        p = mcmd[3:0];
        exp_q.push_back({word ? mdl[4'(p + 1)] : 8'h00, mdl[p]});
        tag_q.push_back(tag);
        drive(word ? 3'd4 : 3'd3, 8'h00, 8'h00, 8'h00);
    endtask

    // Monitor: pops expected read results as they appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk("R9 unexpected read", 32'(rd_data), 32'hFFFF_FFFF);
            else begin
                string t;
                logic [15:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(rd_data), 32'(e));
                chk("R6 ptr kept", 32'(cmd_value), 32'(mcmd));
            end
        end
        if (rst_n && int_clear) clr_seen++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = (i == 1) ? 8'h02 : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", 32'(cmd_value), 32'h00);
        chk("R1 power", 32'(power_ctl), 32'h0);
        chk("R1 timing", 32'(timing_cfg), 32'h02);
        chk("R1 thresholds", {thr_high, thr_low}, 32'h0);
        chk("R1 intr", 32'(intr_cfg), 32'h00);
        chk("R1 ready", 32'(txn_ready), 32'h1);

        // R2 command load, reserved bit 4 dropped
        send(8'h93);
        chk("R2 cmd load", 32'(cmd_value), 32'h83);
        send(8'h05);
        chk("R2 non-command ignored", 32'(cmd_value), 32'h83);
        send(8'hA7);
        chk("R2 word flag", 32'(cmd_value), 32'hA7);

        // R3 clear pulse, bit 6 self clearing
        send(8'hC1);
        chk("R3 one pulse", 32'(clr_seen), 32'd1);
        chk("R3 bit6 reads 0", 32'(cmd_value), 32'h81);

        // R10 / R4 control power
        wbyte(8'h80, 8'h03);
        chk("R10 power up", 32'(power_ctl), 32'h3);
        rd(1'b0, "R10 readback 03");
        wbyte(8'h80, 8'h00);
        chk("R10 power down", 32'(power_ctl), 32'h0);

        // R7 reserved bits
        wbyte(8'h80, 8'hFF);
        rd(1'b0, "R7 control mask");
        wbyte(8'h81, 8'hFF);
        chk("R7 timing mask", 32'(timing_cfg), 32'h1B);
        wbyte(8'h86, 8'hFF);
        chk("R7 intr mask", 32'(intr_cfg), 32'h3F);

        // R5 word writes and R6 word reads
        wword(8'hA2, 8'h34, 8'h12);
        chk("R5 low threshold", 32'(thr_low), 32'h1234);
        rd(1'b1, "R6 read word");
        wword(8'hA4, 8'hCD, 8'hAB);
        chk("R5 high threshold", 32'(thr_high), 32'hABCD);
        rd(1'b0, "R6 read byte");
        wbyte(8'h80, 8'h03);
        wword(8'hAF, 8'h55, 8'h00);
        chk("R5 wrap to address 0", 32'(power_ctl), 32'h0);
        rd(1'b1, "R8 unmapped low byte with wrap");

        // R8 unmapped address
        wbyte(8'h89, 8'h77);
        rd(1'b0, "R8 unmapped read");

        // R2 write with invalid command dropped
        wbyte(8'h82, 8'h11);
        wbyte(8'h02, 8'h99);
        rd(1'b0, "R2 dropped write");

        // R11 unused kind code
        drive(3'd6, 8'hC5, 8'h00, 8'h00);
        chk("R11 unused kind", 32'(cmd_value), 32'(mcmd));
        chk("R11 no pulse", 32'(clr_seen), 32'd1);

        repeat (3) @(negedge clk);
        chk("R9 all reads seen", 32'(exp_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule